// File: doc/BRIEF.md
# Memory Bitfield Operation Unit

This unit carries out one bitfield operation on a memory operand per request. A field is named by a byte address, a signed bit offset counted from the most significant bit of that byte, and a length of 1 to 32 bits. The field may start before or after the addressed byte and may straddle up to five bytes.

On `start` the unit turns the signed offset into a byte address and a bit position of 0 to 7. It picks the smallest power-of-two fetch window (1, 2, 4 or 8 bytes) that covers the field, and moves the window start where needed so that this wider access still covers the field. It reads the window big-endian over a simple request/acknowledge memory port. For the operations that modify the field it writes the updated window back to the same place. It then pulses `done` with a field value and a flag source.

The opcodes are extract unsigned, extract signed, insert, change (invert), clear, set and find-first-one. The flag source is the field left-justified in 32 bits. A surrounding execution unit derives its condition codes from it.

Top module: `bitfield_mem_unit`

## Requirements
- R1: While reset is asserted and right after it, `busy`, `done`, `mem_req` and `mem_we` are low.
- R2: A `fld_len` of 0 selects a 32-bit field. Any other value 1 to 31 is the field length in bits.
- R3: The field starts at bit `bit_off mod 8` (0 = MSB) of byte `base_addr + floor(bit_off/8)`. With k = (bit + len - 1)/8, the read uses `mem_size` 0 (1 byte) for k=0, 1 (2 bytes) for k=1, 2 (4 bytes) for k=2 or 3, and 3 (8 bytes) for k=4. `mem_rdata`/`mem_wdata` hold the window right-justified, with the lowest address in the most significant byte used.
- R4: For k=2 at an odd start byte the window starts one byte lower. For k=4 the window starts at the start byte rounded down to a multiple of 4. In every other case the window starts at the start byte.
- R5: Opcode 0 (extract unsigned) returns the zero-extended field in `res_value`. Opcode 1 (extract signed) returns it sign-extended. Opcode 7 behaves as opcode 0. None of these writes memory.
- R6: Opcode 2 (insert) replaces the field with the low `len` bits of `ins_val`. `res_flag` is `ins_val` shifted left by 32-len.
- R7: Opcodes 3 (change), 4 (clear) and 5 (set) invert, zero or fill the field in memory. Bits outside the field are unchanged.
- R8: Opcode 6 (find-first-one) returns `bit_off` plus the index of the first 1 from the field's MSB. An all-zero field returns `bit_off` plus the length. Memory is not written.
- R9: Exactly one write follows the read for opcodes 2 to 5, with the same address and size as the read. No other opcode writes.
- R10: For every opcode except 2, `res_flag` is the original field left-justified in 32 bits (zeros below). For opcodes 2 to 5, `res_value` is the original zero-extended field.
- R11: `done` is a one-cycle pulse after the last memory acknowledge. `res_value` and `res_flag` hold until the next operation.
- R12: An 8-byte window always starts on a 4-byte boundary, and a 1-byte write carries zeros above bit 7 of `mem_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op | input | 3 | Operation code |
| base_addr | input | 32 | Byte address of the field reference |
| bit_off | input | 32 | Signed bit offset from the MSB of `base_addr` |
| fld_len | input | 5 | Field length, 0 means 32 |
| ins_val | input | 32 | Value for insert |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Window start address |
| mem_size | output | 2 | Window size code (1, 2, 4, 8 bytes) |
| mem_wdata | output | 64 | Write window, right-justified |
| mem_rdata | input | 64 | Read window, right-justified |
| mem_ack | input | 1 | Access complete |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid pulse |
| res_value | output | 32 | Field value or find-first-one position |
| res_flag | output | 32 | Left-justified flag source |

## Verification
The operations run against a byte-level memory model, which walks the field one bit at a time in absolute bit numbering. The stimulus covers positive and negative offsets, offsets larger than a word and each window size class. It includes the odd-address 3-byte realignment, the 5-byte realignment to 4 and both encodings of a 32-bit length. Checking the fetch address and size apart from the data separates a wrong window choice from a wrong shift. Comparing the whole memory after every operation shows stray bits outside the field and writes from opcodes that must not write. An all-zero field separates the find-first-one fallback from the count of leading zeros.

// File: rtl/bitfield_mem_unit.sv
module bitfield_mem_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic [31:0] base_addr,
  input  logic [31:0] bit_off,
  input  logic [4:0]  fld_len,
  input  logic [31:0] ins_val,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [1:0]  mem_size,
  output logic [63:0] mem_wdata,
  input  logic [63:0] mem_rdata,
  input  logic        mem_ack,
  output logic        busy,
  output logic        done,
  output logic [31:0] res_value,
  output logic [31:0] res_flag
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_DONE} state_t;
  state_t st;

  logic [31:0] addr_q, val_q, off_q, val_r, flag_r;
  logic [1:0]  size_q;
  logic [5:0]  bofs_q, len_q;
  logic [2:0]  op_q;
  logic [63:0] win_q;

  // offset canonicalization and window selection
  logic [5:0]  len_c, bofs_c;
  logic [31:0] byte_c, addr_c;
  logic [6:0]  span_c;
  logic [2:0]  extra_c;
  logic [1:0]  size_c;

  assign len_c   = (fld_len == 5'd0) ? 6'd32 : {1'b0, fld_len};
  assign byte_c  = base_addr + 32'($signed(bit_off) >>> 3);
  assign span_c  = {4'd0, bit_off[2:0]} + {1'b0, len_c} - 7'd1;
  assign extra_c = span_c[5:3];

  always_comb begin
    addr_c = byte_c;
    bofs_c = {3'd0, bit_off[2:0]};
    size_c = 2'd0;
    case (extra_c)
      3'd0: bofs_c = bofs_c + 6'd56;
      3'd1: begin bofs_c = bofs_c + 6'd48; size_c = 2'd1; end
      3'd2: begin
        size_c = 2'd2;
        if (byte_c[0]) begin
          addr_c = byte_c - 32'd1;
          bofs_c = bofs_c + 6'd40;
        end else begin
          bofs_c = bofs_c + 6'd32;
        end
      end
      3'd3: begin bofs_c = bofs_c + 6'd32; size_c = 2'd2; end
      default: begin
        size_c = 2'd3;
        addr_c = {byte_c[31:2], 2'b00};
        bofs_c = bofs_c + {1'b0, byte_c[1:0], 3'd0};
      end
    endcase
  end

  // field extraction from the fetched window
  logic [63:0] size_mask, win_in, shl;
  logic [6:0]  rsh;
  logic [31:0] lj, uval, sval, ffo, ins_flag;
  logic [5:0]  lz;
  logic        wr_op;

  assign size_mask = (size_q == 2'd3) ? {64{1'b1}} : ((64'd1 << (7'd8 << size_q)) - 64'd1);
  assign win_in    = mem_rdata & size_mask;
  assign shl       = win_in << bofs_q;
  assign rsh       = 7'd64 - {1'b0, len_q};
  assign lj        = shl[63:32] & ~(32'hFFFF_FFFF >> len_q);
  assign uval      = 32'(shl >> rsh);
  assign sval      = 32'($signed(shl) >>> rsh);
  assign ins_flag  = val_q << (6'd32 - len_q);
  assign ffo       = off_q + ((lj == 32'd0) ? {26'd0, len_q} : {26'd0, lz});
  assign wr_op     = (op_q >= 3'd2) && (op_q <= 3'd5);

  always_comb begin
    lz = 6'd32;
    for (int i = 0; i < 32; i++)
      if (lj[i]) lz = 6'(31 - i);
  end

  always_comb begin
    val_r  = uval;
    flag_r = lj;
    case (op_q)
      3'd1: val_r = sval;
      3'd2: flag_r = ins_flag;
      3'd6: val_r = ffo;
      default: ;
    endcase
  end

  // modified window
  logic [63:0] fmask, ins_bits;
  assign fmask    = ({64{1'b1}} << rsh) >> bofs_q;
  assign ins_bits = (({32'd0, val_q} << rsh) >> bofs_q);

  always_comb begin
    case (op_q)
      3'd2:    mem_wdata = (win_q & ~fmask) | ins_bits;
      3'd3:    mem_wdata = win_q ^ fmask;
      3'd4:    mem_wdata = win_q & ~fmask;
      3'd5:    mem_wdata = win_q | fmask;
      default: mem_wdata = win_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr_q    <= '0;
      size_q    <= '0;
      bofs_q    <= '0;
      len_q     <= 6'd32;
      op_q      <= '0;
      val_q     <= '0;
      off_q     <= '0;
      win_q     <= '0;
      res_value <= '0;
      res_flag  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          addr_q <= addr_c;
          size_q <= size_c;
          bofs_q <= bofs_c;
          len_q  <= len_c;
          op_q   <= op;
          val_q  <= ins_val;
          off_q  <= bit_off;
          st     <= S_READ;
        end
        S_READ: if (mem_ack) begin
          win_q     <= win_in;
          res_value <= val_r;
          res_flag  <= flag_r;
          st        <= wr_op ? S_WRITE : S_DONE;
        end
        S_WRITE: if (mem_ack) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req  = (st == S_READ) || (st == S_WRITE);
  assign mem_we   = (st == S_WRITE);
  assign mem_addr = addr_q;
  assign mem_size = size_q;
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_ack));
  p_write_same_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == $past(mem_addr) && mem_size == $past(mem_size)));
  p_wide_aligned_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_size == 2'd3) |-> (mem_addr[1:0] == 2'b00));
  p_byte_write_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_size == 2'd0) |-> (mem_wdata[63:8] == 56'd0));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done));

endmodule

// File: tb/bitfield_mem_unit_test.sv
module bitfield_mem_unit_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0, mem_ack;
  logic [2:0]  op = '0;
  logic [31:0] base_addr = '0, bit_off = '0, ins_val = '0;
  logic [4:0]  fld_len = '0;
  logic        mem_req, mem_we, busy, done;
  logic [31:0] mem_addr, res_value, res_flag;
  logic [1:0]  mem_size;
  logic [63:0] mem_wdata, mem_rdata;

  bitfield_mem_unit uut (.*);

  int n_chk = 0, n_bad = 0;

  // memory model: 64 bytes, big-endian windows
  logic [7:0]  mem [64];
  logic [7:0]  ref_mem [64];
  int          wr_cnt, rd_addr_log, wr_addr_log;
  logic [1:0]  rd_size_log, wr_size_log;

  function automatic logic [7:0] init_byte(int i);
    if (i >= 32'h30 && i <= 32'h33) return 8'h00;
    return 8'(i * 157 + 91);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wr_cnt    <= 0;
      for (int i = 0; i < 64; i++) mem[i] <= init_byte(i);
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (!mem_we) begin
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < (1 << mem_size); i++) r = (r << 8) | 64'(mem[(mem_addr + i) & 63]);
        mem_rdata   <= r;
        rd_addr_log <= int'(mem_addr);
        rd_size_log <= mem_size;
      end else begin
        for (int i = 0; i < (1 << mem_size); i++)
          mem[(mem_addr + i) & 63] <= 8'(mem_wdata >> (8 * ((1 << mem_size) - 1 - i)));
        wr_cnt      <= wr_cnt + 1;
        wr_addr_log <= int'(mem_addr);
        wr_size_log <= mem_size;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  base;
    logic [31:0] off;
    logic [4:0]  len;
    logic [31:0] val;
    logic [7:0]  xaddr;
    logic [1:0]  xsize;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 8'h20, 32'd3,         5'd5,  32'h0,        8'h20, 2'd0},
    '{3'd1, 8'h20, 32'd13,        5'd7,  32'h0,        8'h21, 2'd1},
    '{3'd1, 8'h21, 32'hFFFF_FFFD, 5'd12, 32'h0,        8'h20, 2'd2},
    '{3'd2, 8'h22, 32'd9,         5'd10, 32'h2A5,      8'h23, 2'd1},
    '{3'd3, 8'h23, 32'd4,         5'd14, 32'h0,        8'h22, 2'd2},
    '{3'd4, 8'h24, 32'd6,         5'd20, 32'h0,        8'h24, 2'd2},
    '{3'd5, 8'h25, 32'd1,         5'd0,  32'h0,        8'h24, 2'd3},
    '{3'd6, 8'h26, 32'hFFFF_FFEF, 5'd9,  32'h0,        8'h23, 2'd1},
    '{3'd6, 8'h30, 32'd10,        5'd12, 32'h0,        8'h31, 2'd1},
    '{3'd0, 8'h27, 32'd0,         5'd0,  32'h0,        8'h27, 2'd2},
    '{3'd2, 8'h2A, 32'd7,         5'd0,  32'hDEADBEEF, 8'h28, 2'd3},
    '{3'd7, 8'h20, 32'd0,         5'd8,  32'h0,        8'h20, 2'd0},
    '{3'd1, 8'h28, 32'd100,       5'd3,  32'h0,        8'h34, 2'd0}
  };

  task automatic run_vec(vec_t v);
    int L, base_bit, w0, first;
    logic [31:0] fld, xval, xflag;
    bit wr_exp;
    L = (v.len == 0) ? 32 : int'(v.len);
    base_bit = int'(v.base) * 8 + $signed(v.off);
    fld = '0;
    first = -1;
    for (int k = 0; k < L; k++) begin
      int p;
      bit b;
      p = base_bit + k;
      b = ref_mem[p >> 3][7 - (p & 7)];
      fld = (fld << 1) | 32'(b);
      if (b && first < 0) first = k;
      case (v.op)
        3'd2: ref_mem[p >> 3][7 - (p & 7)] = v.val[L - 1 - k];
        3'd3: ref_mem[p >> 3][7 - (p & 7)] = ~b;
        3'd4: ref_mem[p >> 3][7 - (p & 7)] = 1'b0;
        3'd5: ref_mem[p >> 3][7 - (p & 7)] = 1'b1;
        default: ;
      endcase
    end
    xval  = fld;
    xflag = fld << (32 - L);
    if (v.op == 3'd1 && L < 32 && fld[L - 1]) xval = fld | ~((32'd1 << L) - 32'd1);
    if (v.op == 3'd2) xflag = v.val << (32 - L);
    if (v.op == 3'd6) xval = $signed(v.off) + ((first < 0) ? L : first);
    wr_exp = (v.op >= 3'd2 && v.op <= 3'd5);

    w0 = wr_cnt;
    @(negedge clk);
    start = 1'b1; op = v.op; base_addr = {24'd0, v.base}; bit_off = v.off;
    fld_len = v.len; ins_val = v.val;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 40 && !done; c++) @(negedge clk);
    check("R11", "done seen", longint'(done), 1);
    check("R3/R4", "read address", rd_addr_log, longint'(v.xaddr));
    check("R3/R2", "read size", longint'(rd_size_log), longint'(v.xsize));
    check("R9", "write count", wr_cnt - w0, wr_exp ? 1 : 0);
    if (wr_exp) begin
      check("R9", "write address", wr_addr_log, longint'(v.xaddr));
      check("R9", "write size", longint'(wr_size_log), longint'(v.xsize));
    end
    case (v.op)
      3'd2: check("R6", "insert flag", res_flag, xflag);
      3'd6: check("R8", "find-first-one", res_value, xval);
      3'd1: check("R5", "signed extract", res_value, xval);
      default: check("R5/R10", "field value", res_value, xval);
    endcase
    if (v.op != 3'd2) check("R10", "flag source", res_flag, xflag);
    else check("R10", "insert old field", res_value, xval);
    begin
      int bad;
      bad = -1;
      for (int i = 63; i >= 0; i--) if (mem[i] !== ref_mem[i]) bad = i;
      check("R7", "memory image", (bad < 0) ? 0 : longint'(mem[bad]),
            (bad < 0) ? 0 : longint'(ref_mem[bad]));
    end
    @(negedge clk);
    check("R11", "done one cycle", longint'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = init_byte(i);
    repeat (4) @(negedge clk);
    check("R1", "busy in reset", longint'(busy), 0);
    check("R1", "req in reset", longint'({mem_req, mem_we, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset", longint'({busy, mem_req, mem_we, done}), 0);

    for (int n = 0; n < NV; n++) run_vec(TBL[n]);

    // R11: results hold while idle
    begin
      logic [31:0] hv, hf;
      hv = res_value; hf = res_flag;
      repeat (5) @(negedge clk);
      check("R11", "value held", res_value, hv);
      check("R11", "flag held", res_flag, hf);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule